// File: doc/BRIEF.md
# Level-Match GPIO Controller with Alternate Functions

A 32-pin general-purpose I/O block with six word-wide registers on a simple synchronous register bus. For each pin, software picks between two owners. As a GPIO, the pin is either an input or an output driven from the data register. Otherwise an external alternate-function path supplies the pin's output value and output enable.

Every pin input passes through a two-flop synchroniser. The synchronised value is what software reads back from the data register. It also feeds a per-pin comparison against a programmable level. When the two are equal, a sticky status bit sets and stays set until software overwrites it.

A per-pin routing enable sends each pending status bit to one of two places. Bits with the enable set go to the non-maskable interrupt output. Bits with the enable clear go to the normal interrupt request.

Top module: `gpio_lm_ctrl`

## Requirements
- R1: After reset, function select, direction, output data and NMI-route registers are all zeros, the level register is all ones, status is zero, and `pin_oe_o` is zero.
- R2: Word offsets 0x00 function select, 0x04 direction, 0x08 data, 0x0C match level, 0x10 status and 0x14 NMI route read back what was last written. The exceptions are data, which reads the pin state, and status.
- R3: A read with `addr_i` bits [1:0] nonzero, or at a word offset of 0x18 or above, returns zero. A write to such an address changes no register.
- R4: A pin with function bit 0 drives `pin_out_o` from the written data bit, with `pin_oe_o` equal to its direction bit (1 = output). A pin with function bit 1 passes `alt_out_i` and `alt_oe_i` through.
- R5: Reading offset 0x08 returns `pin_in_i` as it was two clock edges earlier. A change of the pin becomes visible after the second rising edge.
- R6: A status bit sets on the clock edge after its synchronised pin value equals its level bit. Once set, it stays set when the match goes away.
- R7: A write to offset 0x10 replaces the status with the written value on that edge. On the next edge, any bit whose match still holds is set again.
- R8: `nmi_o` is high when any set status bit has its route bit at 1. `irq_o` is high when any set status bit has its route bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pin_in_i | input | 32 | Pad input values (asynchronous) |
| pin_out_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad output enables |
| alt_out_i | input | 32 | Alternate-function output values |
| alt_oe_i | input | 32 | Alternate-function output enables |
| irq_o | output | 1 | Normal interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
A corrupted configuration register shows up on `pin_out_o` or `pin_oe_o` in the same cycle it is read, because the pad mux is purely combinational from the stored bits. A fault in the synchroniser or the status register shows up within one edge as a wrong data or status readback. A broken sticky or replace rule shows up on `irq_o` or `nmi_o` the cycle after the offending write or pin change. The bench therefore samples readbacks at precise edge counts after each pin change or status write, so that an off-by-one latency is caught.

// File: rtl/gpio_lm_pkg.sv
package gpio_lm_pkg;
  localparam int unsigned NUM_REGS  = 6;
  localparam int unsigned REG_FUNC  = 0;
  localparam int unsigned REG_DIR   = 1;
  localparam int unsigned REG_DATA  = 2;
  localparam int unsigned REG_LEVEL = 3;
  localparam int unsigned REG_STAT  = 4;
  localparam int unsigned REG_NMIEN = 5;
endpackage

// File: rtl/gpio_lm_sync.sv
module gpio_lm_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_lm_regs.sv
module gpio_lm_regs
  import gpio_lm_pkg::*;
#(
  parameter int unsigned     WIDTH     = 32,
  parameter int unsigned     ADDR_W    = 5,
  parameter logic [WIDTH-1:0] LEVEL_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_sync_i,
  input  logic [WIDTH-1:0]  stat_i,
  output logic [WIDTH-1:0]  func_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  dout_o,
  output logic [WIDTH-1:0]  level_o,
  output logic [WIDTH-1:0]  nmi_en_o,
  output logic              stat_wr_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             mapped;
  logic             wr;
  logic [WIDTH-1:0] func_q, dir_q, dout_q, level_q, nmi_en_q;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign mapped  = aligned && (int'(idx) < NUM_REGS);
  assign wr      = req_i && we_i && mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q   <= '0;
      dir_q    <= '0;
      dout_q   <= '0;
      level_q  <= LEVEL_RST;
      nmi_en_q <= '0;
    end else if (wr) begin
      case (int'(idx))
        REG_FUNC:  func_q   <= wdata_i;
        REG_DIR:   dir_q    <= wdata_i;
        REG_DATA:  dout_q   <= wdata_i;
        REG_LEVEL: level_q  <= wdata_i;
        REG_NMIEN: nmi_en_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign stat_wr_o = wr && (int'(idx) == REG_STAT);

  always_comb begin
    rdata_o = '0;
    if (mapped) begin
      case (int'(idx))
        REG_FUNC:  rdata_o = func_q;
        REG_DIR:   rdata_o = dir_q;
        REG_DATA:  rdata_o = pin_sync_i;
        REG_LEVEL: rdata_o = level_q;
        REG_STAT:  rdata_o = stat_i;
        REG_NMIEN: rdata_o = nmi_en_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign func_o   = func_q;
  assign dir_o    = dir_q;
  assign dout_o   = dout_q;
  assign level_o  = level_q;
  assign nmi_en_o = nmi_en_q;

  assert_unmapped_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |-> (rdata_o == '0));

  assert_unmapped_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !mapped) |=> ($stable(func_q) && $stable(dir_q) && $stable(dout_q)
                                    && $stable(level_q) && $stable(nmi_en_q)));
endmodule

// File: rtl/gpio_lm_status.sv
module gpio_lm_status #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_sync_i,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] nmi_en_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] stat_o,
  output logic             irq_o,
  output logic             nmi_o
);
  logic [WIDTH-1:0] match;
  logic [WIDTH-1:0] stat_q;

  assign match = ~(pin_sync_i ^ level_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stat_q <= '0;
    else if (wr_i) stat_q <= wdata_i;
    else           stat_q <= stat_q | match;
  end

  assign stat_o = stat_q;
  assign nmi_o  = |(stat_q & nmi_en_i);
  assign irq_o  = |(stat_q & ~nmi_en_i);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_match_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((stat_q & $past(match)) == $past(match)));

  assert_write_replaces_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (stat_q == $past(wdata_i)));
endmodule

// File: rtl/gpio_lm_padmux.sv
module gpio_lm_padmux #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] func_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] dout_i,
  input  logic [WIDTH-1:0] alt_out_i,
  input  logic [WIDTH-1:0] alt_oe_i,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pin_out_o[i] = func_i[i] ? alt_out_i[i] : dout_i[i];
    assign pin_oe_o[i]  = func_i[i] ? alt_oe_i[i]  : dir_i[i];
  end
endmodule

// File: rtl/gpio_lm_ctrl.sv
module gpio_lm_ctrl #(
  parameter int unsigned      NUM_PINS  = 32,
  parameter int unsigned      ADDR_W    = 5,
  parameter logic [NUM_PINS-1:0] LEVEL_RST = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  input  logic [NUM_PINS-1:0] alt_out_i,
  input  logic [NUM_PINS-1:0] alt_oe_i,
  output logic                irq_o,
  output logic                nmi_o
);
  logic [NUM_PINS-1:0] pin_sync, stat, func, dir, dout, level, nmi_en;
  logic                stat_wr;

  gpio_lm_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_in_i),
    .sync_o  (pin_sync)
  );

  gpio_lm_regs #(.WIDTH(NUM_PINS), .ADDR_W(ADDR_W), .LEVEL_RST(LEVEL_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .pin_sync_i (pin_sync),
    .stat_i     (stat),
    .func_o     (func),
    .dir_o      (dir),
    .dout_o     (dout),
    .level_o    (level),
    .nmi_en_o   (nmi_en),
    .stat_wr_o  (stat_wr)
  );

  gpio_lm_status #(.WIDTH(NUM_PINS)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_sync_i (pin_sync),
    .level_i    (level),
    .nmi_en_i   (nmi_en),
    .wr_i       (stat_wr),
    .wdata_i    (wdata_i),
    .stat_o     (stat),
    .irq_o      (irq_o),
    .nmi_o      (nmi_o)
  );

  gpio_lm_padmux #(.WIDTH(NUM_PINS)) u_padmux (
    .func_i    (func),
    .dir_i     (dir),
    .dout_i    (dout),
    .alt_out_i (alt_out_i),
    .alt_oe_i  (alt_oe_i),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
  );

  assert_pending_signalled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat != '0) |-> (irq_o || nmi_o));

  assert_gpio_input_undriven_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o & ~func & ~dir) == '0));
endmodule

// File: tb/gpio_lm_ctrl_tb.sv
module gpio_lm_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  localparam logic [4:0] A_FUNC = 5'h00, A_DIR = 5'h04, A_DATA = 5'h08,
                         A_LVL = 5'h0C, A_STAT = 5'h10, A_NMI = 5'h14;

  // func, dir, dout, alt_out, alt_oe, exp_out, exp_oe
  localparam logic [31:0] MUX_TAB [5][7] = '{
    '{32'h0,        32'h0,        32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0},
    '{32'h0,        32'hFFFFFFFF, 32'hA5A5A5A5, 32'h0,        32'h0,        32'hA5A5A5A5, 32'hFFFFFFFF},
    '{32'hFFFFFFFF, 32'h0,        32'h12345678, 32'h87654321, 32'h0F0F0F0F, 32'h87654321, 32'h0F0F0F0F},
    '{32'hFFFF0000, 32'h00FF00FF, 32'hAAAAAAAA, 32'h55555555, 32'hFFFFFFFF, 32'h5555AAAA, 32'hFFFF00FF},
    '{32'h0000FFFF, 32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 32'h0,        32'h0000FFFF, 32'hFFFF0000}
  };

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [4:0] addr = '0;
  logic [N-1:0] wdata = '0, pin_in = '0, alt_out = '0, alt_oe = '0;
  logic [N-1:0] rdata, pin_out, pin_oe;
  logic irq, nmi;
  int checks = 0, errors = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_lm_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_in_i(pin_in), .pin_out_o(pin_out),
    .pin_oe_o(pin_oe), .alt_out_i(alt_out), .alt_oe_i(alt_oe),
    .irq_o(irq), .nmi_o(nmi)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd_now(input logic [4:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    #1;
    d = rdata;
    req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_now(A_FUNC, rd); chk("R1 func", rd, 32'h0);
    rd_now(A_DIR,  rd); chk("R1 dir",  rd, 32'h0);
    rd_now(A_LVL,  rd); chk("R1 level", rd, 32'hFFFFFFFF);
    rd_now(A_STAT, rd); chk("R1 status", rd, 32'h0);
    rd_now(A_NMI,  rd); chk("R1 nmi route", rd, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq/nmi", {30'h0, irq, nmi}, 32'h0);

    // R2 readback
    wr(A_FUNC, 32'h13572468); wr(A_DIR, 32'hCAFEF00D);
    wr(A_LVL, 32'h0F1E2D3C);  wr(A_NMI, 32'h600DBEEF);
    @(negedge clk);
    rd_now(A_FUNC, rd); chk("R2 func", rd, 32'h13572468);
    rd_now(A_DIR,  rd); chk("R2 dir",  rd, 32'hCAFEF00D);
    rd_now(A_LVL,  rd); chk("R2 level", rd, 32'h0F1E2D3C);
    rd_now(A_NMI,  rd); chk("R2 nmi route", rd, 32'h600DBEEF);

    // R3 unmapped and misaligned
    wr(5'h18, 32'hFFFFFFFF); wr(5'h1C, 32'h0); wr(5'h01, 32'h0); wr(5'h06, 32'h0);
    rd_now(5'h18, rd); chk("R3 rd 0x18", rd, 32'h0);
    rd_now(5'h1C, rd); chk("R3 rd 0x1C", rd, 32'h0);
    rd_now(5'h05, rd); chk("R3 rd misaligned", rd, 32'h0);
    rd_now(A_FUNC, rd); chk("R3 func untouched", rd, 32'h13572468);
    rd_now(A_DIR,  rd); chk("R3 dir untouched",  rd, 32'hCAFEF00D);
    rd_now(A_NMI,  rd); chk("R3 nmi untouched",  rd, 32'h600DBEEF);

    wr(A_FUNC, 0); wr(A_DIR, 0); wr(A_LVL, 32'hFFFFFFFF); wr(A_NMI, 0); wr(A_STAT, 0);
    @(negedge clk);

    // R4 table
    for (int i = 0; i < 5; i++) begin
      wr(A_FUNC, MUX_TAB[i][0]); wr(A_DIR, MUX_TAB[i][1]); wr(A_DATA, MUX_TAB[i][2]);
      alt_out = MUX_TAB[i][3]; alt_oe = MUX_TAB[i][4];
      #1;
      chk($sformatf("R4 row%0d out", i), pin_out, MUX_TAB[i][5]);
      chk($sformatf("R4 row%0d oe", i),  pin_oe,  MUX_TAB[i][6]);
    end
    wr(A_FUNC, 0); wr(A_DIR, 0); wr(A_DATA, 0); alt_out = '0; alt_oe = '0;

    // R5 synchroniser latency
    @(negedge clk);
    pin_in = 32'h8000_0101;
    @(negedge clk);
    rd_now(A_DATA, rd); chk("R5 after 1 edge", rd, 32'h0);
    @(negedge clk);
    rd_now(A_DATA, rd); chk("R5 after 2 edges", rd, 32'h8000_0101);
    rd_now(A_STAT, rd); chk("R6 not yet set", rd, 32'h0);
    @(negedge clk);
    rd_now(A_STAT, rd); chk("R6 high match set", rd, 32'h8000_0101);
    pin_in = '0;
    repeat (3) @(negedge clk);
    rd_now(A_STAT, rd); chk("R6 sticky after pin drop", rd, 32'h8000_0101);
    wr(A_STAT, 0);
    @(negedge clk);
    rd_now(A_STAT, rd); chk("R7 cleared no match", rd, 32'h0);
    chk("R8 idle", {30'h0, irq, nmi}, 32'h0);

    // R6 low-level match
    wr(A_LVL, 32'hFFFFFFF0);
    rd_now(A_STAT, rd); chk("R6 one edge after level", rd, 32'h0);
    @(negedge clk);
    rd_now(A_STAT, rd); chk("R6 low match set", rd, 32'h0000000F);
    wr(A_LVL, 32'hFFFFFFFF);
    @(negedge clk);
    rd_now(A_STAT, rd); chk("R6 sticky after level change", rd, 32'h0000000F);

    // R7 replace while match holds
    wr(A_LVL, 32'hFFFFFFF0);
    wr(A_STAT, 32'h0000_0105);
    rd_now(A_STAT, rd); chk("R7 replaced", rd, 32'h0000_0105);
    @(negedge clk);
    rd_now(A_STAT, rd); chk("R7 re-set by match", rd, 32'h0000_010F);

    // R8 routing
    chk("R8 irq only", {30'h0, irq, nmi}, 32'h2);
    wr(A_NMI, 32'h0000_010F);
    chk("R8 nmi only", {30'h0, irq, nmi}, 32'h1);
    wr(A_NMI, 32'h0000_0003);
    chk("R8 both", {30'h0, irq, nmi}, 32'h3);
    wr(A_LVL, 32'hFFFFFFFF);
    wr(A_STAT, 0);
    @(negedge clk);
    chk("R8 cleared", {30'h0, irq, nmi}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule